// File: doc/BRIEF.md
# Sector and Packet Re-blocking Bridge

This block sits between a storage device that works in 512-byte sectors and a USB bulk endpoint pair that moves 64-byte packets. It holds one sector in a single local buffer. A command names a direction, a first logical block and a sector count. For a read (IN) command the block asks storage for one sector, fills the buffer and then streams the sector to the IN endpoint as eight full packets. Each packet carries start and end markers, and the block waits for the host's acknowledge after each packet.

For a write (OUT) command the block takes received bytes into the buffer regardless of packet boundaries. It hands data to storage only when a whole sector has been collected. A one-cycle strobe and the sector's byte address open a 512-cycle burst toward the storage write port. A phase output follows the transfer: 0 while waiting for a command, 1 during OUT data, 2 during IN data and 4 for one cycle once the final sector has gone through. The block then accepts the next command.

Top module: `sector_pkt_bridge`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only in phase 0. While a command runs, `cmd_valid` and the command fields have no effect on addresses, data or sector counts.
- R2: For each sector of an IN command, `st_rd_req` pulses high for exactly one cycle with `st_rd_addr` equal to the sector number shifted left by 9. Sectors are requested in increasing order from `cmd_lba`, and the sector number wraps modulo 2^32.
- R3: Each IN sector goes out as eight 64-byte packets in the order storage delivered the bytes. A byte moves on an edge with `tx_valid` and `tx_ready` both high. `tx_first` marks byte 0 of a packet and `tx_last` marks byte 63.
- R4: After the last byte of a packet, `tx_valid` stays low until an `tx_ack` pulse. The next sector request is issued only after all eight packets of the current sector have been acknowledged.
- R5: OUT bytes are stored on edges with `rx_valid` and `rx_ready` both high. After every 512th byte of a command, `st_wr_go` pulses high together with the first of 512 consecutive `st_wr_valid` cycles, which carry the sector's bytes in arrival order. `st_wr_addr` is the sector number shifted left by 9, with sector numbers following on from `cmd_lba`.
- R6: Storage sees a write only after a whole 512-byte sector has arrived. `rx_ready` is low during each write burst.
- R7: `phase` reads 1 during OUT data, 2 during IN data and 4 for exactly one cycle after the final sector. Phase 4 follows the eighth acknowledge of the last IN sector or the last byte of the last write burst. The next cycle returns to 0 with `cmd_ready` high.
- R8: A command with `cmd_count` of 0 goes to phase 4 on the cycle after acceptance, with no storage request, no packet and no write burst.
- R9: While reset is asserted and right after it, `cmd_ready` is high, `phase` is 0 and `st_rd_req`, `tx_valid`, `rx_ready`, `st_wr_go` and `st_wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Idle, able to take a command |
| cmd_write | input | 1 | 1 = OUT (host to storage), 0 = IN |
| cmd_lba | input | 32 | First sector number |
| cmd_count | input | 16 | Number of sectors |
| st_rd_req | output | 1 | One-cycle sector fetch request |
| st_rd_addr | output | 41 | Byte address of sector to fetch |
| st_rd_valid | input | 1 | Storage byte present |
| st_rd_data | input | 8 | Storage byte |
| tx_valid | output | 1 | IN byte present |
| tx_ready | input | 1 | Endpoint takes IN byte |
| tx_data | output | 8 | IN byte |
| tx_first | output | 1 | First byte of a packet |
| tx_last | output | 1 | Last byte of a packet |
| tx_ack | input | 1 | Host acknowledged the last packet |
| rx_valid | input | 1 | OUT byte present |
| rx_ready | output | 1 | Block takes OUT byte |
| rx_data | input | 8 | OUT byte |
| st_wr_go | output | 1 | Sector complete, write burst starts |
| st_wr_addr | output | 41 | Byte address of sector being written |
| st_wr_valid | output | 1 | Write burst byte present |
| st_wr_data | output | 8 | Write burst byte |
| phase | output | 3 | Transfer phase code 0, 1, 2 or 4 |

## Verification
A byte index that slips inside the sequencer shows on the very next IN byte as a wrong packet marker or wrong data. On the OUT path it shows as a write burst that starts early or late against the bench's own byte count. A sector number or remaining-count error shows at the next storage request or write strobe as a wrong address, or at command end as phase 4 arriving with the wrong number of packets or sectors. A state that fails to wait for the acknowledge shows within one cycle as `tx_valid` rising, or `st_rd_req` firing, while the bench still holds its acknowledge back.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int SECTOR_BYTES_D = 512;
    localparam int PKT_BYTES_D    = 64;
    localparam int LBA_W_D        = 32;
    localparam int CNT_W_D        = 16;
    localparam int DATA_W_D       = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_SEND,
        S_WAIT_ACK,
        S_RECV,
        S_FLUSH,
        S_STATUS
    } seq_state_e;

    typedef enum logic [2:0] {
        PH_CMD    = 3'd0,
        PH_OUT    = 3'd1,
        PH_IN     = 3'd2,
        PH_STATUS = 3'd4
    } phase_e;

    typedef struct packed {
        logic first;
        logic last;
    } pkt_marks_t;

    function automatic phase_e phase_of(input seq_state_e s);
        case (s)
            S_FETCH, S_SEND, S_WAIT_ACK: return PH_IN;
            S_RECV, S_FLUSH:             return PH_OUT;
            S_STATUS:                    return PH_STATUS;
            default:                     return PH_CMD;
        endcase
    endfunction

endpackage

// File: rtl/seg_sector_ram.sv
module seg_sector_ram #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/seg_sequencer.sv
module seg_sequencer
    import seg_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int PKT_BYTES    = 64,
    parameter int LBA_W        = 32,
    parameter int CNT_W        = 16,
    localparam int IDX_W       = $clog2(SECTOR_BYTES),
    localparam int OFF_W       = $clog2(PKT_BYTES),
    localparam int PKTS        = SECTOR_BYTES / PKT_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [LBA_W-1:0] cmd_lba,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             rd_valid,
    input  logic             tx_ready,
    input  logic             tx_ack,
    input  logic             rx_valid,
    output seq_state_e       state,
    output logic [IDX_W-1:0] idx,
    output logic [LBA_W-1:0] lba,
    output logic             mem_we,
    output logic             rd_req
);

    localparam int ACK_W = $clog2(PKTS + 1);

    logic [CNT_W-1:0] left;
    logic             idx_end;
    logic             pkt_end;
    logic             last_sector;

    assign idx_end     = (idx == IDX_W'(SECTOR_BYTES - 1));
    assign pkt_end     = (idx[OFF_W-1:0] == OFF_W'(PKT_BYTES - 1));
    assign last_sector = (left == CNT_W'(1));
    assign mem_we      = (state == S_FETCH && rd_valid) || (state == S_RECV && rx_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            idx    <= '0;
            lba    <= '0;
            left   <= '0;
            rd_req <= 1'b0;
        end else begin
            rd_req <= 1'b0;
            case (state)
                S_IDLE: if (cmd_valid) begin
                    lba  <= cmd_lba;
                    left <= cmd_count;
                    idx  <= '0;
                    if (cmd_count == '0) begin
                        state <= S_STATUS;
                    end else if (cmd_write) begin
                        state <= S_RECV;
                    end else begin
                        state  <= S_FETCH;
                        rd_req <= 1'b1;
                    end
                end
                S_FETCH: if (rd_valid) begin
                    idx <= idx + 1'b1;
                    if (idx_end) state <= S_SEND;
                end
                S_SEND: if (tx_ready) begin
                    idx <= idx + 1'b1;
                    if (pkt_end) state <= S_WAIT_ACK;
                end
                S_WAIT_ACK: if (tx_ack) begin
                    if (idx == '0) begin
                        left <= left - 1'b1;
                        lba  <= lba + 1'b1;
                        if (last_sector) begin
                            state <= S_STATUS;
                        end else begin
                            state  <= S_FETCH;
                            rd_req <= 1'b1;
                        end
                    end else begin
                        state <= S_SEND;
                    end
                end
                S_RECV: if (rx_valid) begin
                    idx <= idx + 1'b1;
                    if (idx_end) state <= S_FLUSH;
                end
                S_FLUSH: begin
                    idx <= idx + 1'b1;
                    if (idx_end) begin
                        left  <= left - 1'b1;
                        lba   <= lba + 1'b1;
                        state <= last_sector ? S_STATUS : S_RECV;
                    end
                end
                S_STATUS: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // Acknowledge tally between fetches, kept for the checks below only.
    logic [ACK_W-1:0] acks_seen;
    logic             fetched_once;

    always_ff @(posedge clk) begin
        if (rst || state == S_IDLE) begin
            acks_seen    <= '0;
            fetched_once <= 1'b0;
        end else if (rd_req) begin
            acks_seen    <= '0;
            fetched_once <= 1'b1;
        end else if (state == S_WAIT_ACK && tx_ack) begin
            acks_seen <= acks_seen + 1'b1;
        end
    end

    a_r4_fetch_after_all_acks: assert property (@(posedge clk) disable iff (rst)
        (rd_req && fetched_once) |-> (acks_seen == ACK_W'(PKTS)));

    a_r2_req_single_cycle: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    a_r7_status_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (state == S_STATUS) |=> (state == S_IDLE));

    a_r8_zero_count_status: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && cmd_valid && cmd_count == '0) |=> (state == S_STATUS));

    a_r6_flush_on_full_sector: assert property (@(posedge clk) disable iff (rst)
        (state == S_RECV && rx_valid && idx != IDX_W'(SECTOR_BYTES - 1)) |=> (state == S_RECV));

endmodule

// File: rtl/sector_pkt_bridge.sv
module sector_pkt_bridge
    import seg_pkg::*;
#(
    parameter int SECTOR_BYTES = SECTOR_BYTES_D,
    parameter int PKT_BYTES    = PKT_BYTES_D,
    parameter int LBA_W        = LBA_W_D,
    parameter int CNT_W        = CNT_W_D,
    parameter int DATA_W       = DATA_W_D,
    localparam int IDX_W       = $clog2(SECTOR_BYTES),
    localparam int OFF_W       = $clog2(PKT_BYTES),
    localparam int ADDR_W      = LBA_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [LBA_W-1:0]  cmd_lba,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              st_rd_req,
    output logic [ADDR_W-1:0] st_rd_addr,
    input  logic              st_rd_valid,
    input  logic [DATA_W-1:0] st_rd_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_first,
    output logic              tx_last,
    input  logic              tx_ack,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    output logic              st_wr_go,
    output logic [ADDR_W-1:0] st_wr_addr,
    output logic              st_wr_valid,
    output logic [DATA_W-1:0] st_wr_data,
    output logic [2:0]        phase
);

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [LBA_W-1:0]  lba;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    pkt_marks_t        marks;
    logic [OFF_W-1:0]  off;

    seg_sequencer #(
        .SECTOR_BYTES(SECTOR_BYTES),
        .PKT_BYTES   (PKT_BYTES),
        .LBA_W       (LBA_W),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_write(cmd_write),
        .cmd_lba  (cmd_lba),
        .cmd_count(cmd_count),
        .rd_valid (st_rd_valid),
        .tx_ready (tx_ready),
        .tx_ack   (tx_ack),
        .rx_valid (rx_valid),
        .state    (state),
        .idx      (idx),
        .lba      (lba),
        .mem_we   (mem_we),
        .rd_req   (st_rd_req)
    );

    assign mem_wdata = (state == S_FETCH) ? st_rd_data : rx_data;

    seg_sector_ram #(
        .DEPTH (SECTOR_BYTES),
        .DATA_W(DATA_W)
    ) u_ram (
        .clk  (clk),
        .we   (mem_we),
        .waddr(idx),
        .wdata(mem_wdata),
        .raddr(idx),
        .rdata(mem_rdata)
    );

    assign off         = idx[OFF_W-1:0];
    assign marks.first = (off == '0);
    assign marks.last  = (off == OFF_W'(PKT_BYTES - 1));

    assign cmd_ready   = (state == S_IDLE);
    assign st_rd_addr  = {lba, {IDX_W{1'b0}}};
    assign st_wr_addr  = {lba, {IDX_W{1'b0}}};
    assign tx_valid    = (state == S_SEND);
    assign tx_data     = mem_rdata;
    assign tx_first    = tx_valid && marks.first;
    assign tx_last     = tx_valid && marks.last;
    assign rx_ready    = (state == S_RECV);
    assign st_wr_valid = (state == S_FLUSH);
    assign st_wr_go    = st_wr_valid && (idx == '0);
    assign st_wr_data  = mem_rdata;
    assign phase       = phase_of(state);

    a_r3_marks_distinct: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !(tx_first && tx_last));

    a_r6_no_rx_during_burst: assert property (@(posedge clk) disable iff (rst)
        st_wr_valid |-> !rx_ready);

    a_r4_hold_after_last: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (phase == 3'd0));

    a_r5_go_opens_burst: assert property (@(posedge clk) disable iff (rst)
        (st_wr_valid && !st_wr_go) |-> $past(st_wr_valid));

endmodule

// File: tb/sim_sector_pkt_bridge.sv
`timescale 1ns/100ps
module sim_sector_pkt_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_lba = '0;
    logic [15:0] cmd_count = '0;
    logic        st_rd_req;
    logic [40:0] st_rd_addr;
    logic        st_rd_valid = 1'b0;
    logic [7:0]  st_rd_data = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_first, tx_last;
    logic        tx_ack = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        st_wr_go;
    logic [40:0] st_wr_addr;
    logic        st_wr_valid;
    logic [7:0]  st_wr_data;
    logic [2:0]  phase;

    always #2.5 clk = ~clk;

    sector_pkt_bridge u0 (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_lba(cmd_lba), .cmd_count(cmd_count),
        .st_rd_req(st_rd_req), .st_rd_addr(st_rd_addr),
        .st_rd_valid(st_rd_valid), .st_rd_data(st_rd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last), .tx_ack(tx_ack),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .st_wr_go(st_wr_go), .st_wr_addr(st_wr_addr),
        .st_wr_valid(st_wr_valid), .st_wr_data(st_wr_data),
        .phase(phase)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Expected-value state shared by the bench processes.
    logic [31:0] exp_rd_sec, exp_in_sec, exp_wr_sec;
    int  in_pos = 0, wr_pos = 0;
    int  pkts = 0, acks = 0, fetches = 0, wsecs = 0;
    int  acks_since_fetch = 0;
    bit  first_fetch = 1;
    int  rx_sent = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_byte(input logic [40:0] a);
        return a[7:0] ^ a[16:9] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] wr_byte(input logic [31:0] sec, input int i);
        int v;
        v = int'(sec[7:0]) * 37 + i * 5 + i / 256;
        return v[7:0];
    endfunction

    // Storage read side: answers each request with 512 bytes and random gaps.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && st_rd_req) begin
                logic [40:0] a;
                a = st_rd_addr;
                fetches++;
                check(st_rd_addr == {exp_rd_sec, 9'b0}, "R2 fetch address", st_rd_addr, {exp_rd_sec, 9'b0});
                check(first_fetch || acks_since_fetch == 8, "R4 fetch after eight acks", acks_since_fetch, 8);
                first_fetch = 0;
                acks_since_fetch = 0;
                exp_rd_sec = exp_rd_sec + 1;
                for (int b = 0; b < 512; b++) begin
                    repeat ($urandom % 3) @(negedge clk);
                    st_rd_valid = 1'b1;
                    st_rd_data  = rd_byte(a + 41'(b));
                    @(negedge clk);
                    check(!st_rd_req, "R2 request pulse width", st_rd_req, 0);
                    st_rd_valid = 1'b0;
                end
            end
        end
    end

    // IN endpoint sink with delayed acknowledge.
    initial begin
        bit pend;
        int cd;
        pend = 0;
        cd = 0;
        forever begin
            bit was_pend;
            @(negedge clk);
            was_pend = pend;
            tx_ack = 1'b0;
            if (pend) begin
                if (cd == 0) begin
                    tx_ack = 1'b1;
                    pend = 0;
                    acks++;
                    acks_since_fetch++;
                end else begin
                    cd--;
                end
            end
            if (was_pend) check(!tx_valid, "R4 no byte before ack", tx_valid, 0);
            tx_ready = ($urandom % 4) != 0;
            if (!rst && tx_valid && tx_ready && !was_pend) begin
                check(tx_data == rd_byte({exp_in_sec, 9'b0} + 41'(in_pos)), "R3 data",
                      tx_data, rd_byte({exp_in_sec, 9'b0} + 41'(in_pos)));
                check(tx_first == (in_pos % 64 == 0), "R3 first marker", tx_first, in_pos % 64 == 0);
                check(tx_last == (in_pos % 64 == 63), "R3 last marker", tx_last, in_pos % 64 == 63);
                if (in_pos % 64 == 63) begin
                    pend = 1;
                    cd = $urandom % 3;
                    pkts++;
                end
                in_pos++;
                if (in_pos == 512) begin
                    in_pos = 0;
                    exp_in_sec = exp_in_sec + 1;
                end
            end
        end
    end

    // Storage write side monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && st_wr_valid) begin
                check(st_wr_go == (wr_pos == 0), "R5 go marks burst start", st_wr_go, wr_pos == 0);
                if (st_wr_go) begin
                    check(st_wr_addr == {exp_wr_sec, 9'b0}, "R5 write address", st_wr_addr, {exp_wr_sec, 9'b0});
                    check(rx_sent == (wsecs + 1) * 512, "R6 whole sector before write", rx_sent, (wsecs + 1) * 512);
                end
                check(st_wr_data == wr_byte(exp_wr_sec, wr_pos), "R5 write data", st_wr_data, wr_byte(exp_wr_sec, wr_pos));
                check(!rx_ready, "R6 rx held during burst", rx_ready, 0);
                wr_pos++;
                if (wr_pos == 512) begin
                    wr_pos = 0;
                    wsecs++;
                    exp_wr_sec = exp_wr_sec + 1;
                end
            end else if (!rst) begin
                check(!st_wr_go, "R5 no stray go", st_wr_go, 0);
            end
        end
    end

    task automatic run_cmd(input bit wr, input logic [31:0] lba, input int cnt);
        int p0, a0, f0, guard;
        logic [2:0] exp_ph;
        while (!cmd_ready) @(negedge clk);
        exp_rd_sec = lba; exp_in_sec = lba; exp_wr_sec = lba;
        in_pos = 0; wr_pos = 0; wsecs = 0; rx_sent = 0;
        first_fetch = 1; acks_since_fetch = 0;
        p0 = pkts; a0 = acks; f0 = fetches;
        cmd_valid = 1'b1; cmd_write = wr; cmd_lba = lba; cmd_count = 16'(cnt);
        @(negedge clk);
        cmd_valid = 1'b0;
        exp_ph = (cnt == 0) ? 3'd4 : (wr ? 3'd1 : 3'd2);
        check(phase == exp_ph, (cnt == 0) ? "R8 zero count status" : "R7 phase after accept", phase, exp_ph);
        check(!cmd_ready, "R1 busy after accept", cmd_ready, 0);
        if (wr) begin
            while (rx_sent < cnt * 512) begin
                if (rx_ready && ($urandom % 3) != 0) begin
                    rx_valid = 1'b1;
                    rx_data  = wr_byte(lba + 32'(rx_sent / 512), rx_sent % 512);
                    rx_sent++;
                end else begin
                    rx_valid = 1'b0;
                end
                cmd_valid = !cmd_ready && ($urandom % 8 == 0);
                cmd_lba = $urandom; cmd_count = 16'($urandom); cmd_write = $urandom;
                @(negedge clk);
            end
            rx_valid = 1'b0;
        end
        guard = 0;
        while (phase != 3'd4 && guard < 20000) begin
            cmd_valid = !cmd_ready && ($urandom % 8 == 0);
            cmd_lba = $urandom; cmd_count = 16'($urandom); cmd_write = $urandom;
            @(negedge clk);
            guard++;
        end
        cmd_valid = 1'b0;
        check(phase == 3'd4, "R7 status reached", phase, 4);
        if (wr) begin
            check(wsecs == cnt, "R5 sectors written", wsecs, cnt);
            check(wr_pos == 0, "R6 no partial burst", wr_pos, 0);
        end else begin
            check(pkts - p0 == cnt * 8, "R3 packets per command", pkts - p0, cnt * 8);
            check(acks - a0 == cnt * 8, "R7 status after final ack", acks - a0, cnt * 8);
            check(fetches - f0 == cnt, "R2 fetches per command", fetches - f0, cnt);
        end
        if (cnt == 0) begin
            check(fetches == f0 && pkts == p0 && wsecs == 0, "R8 no transfer", fetches - f0, 0);
        end
        @(negedge clk);
        check(phase == 3'd0, "R7 back to command phase", phase, 0);
        check(cmd_ready, "R1 ready after status", cmd_ready, 1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        check(cmd_ready && phase == 0, "R9 reset ready and phase", {cmd_ready, phase}, 4'b1000);
        check(!st_rd_req && !tx_valid && !rx_ready && !st_wr_go && !st_wr_valid, "R9 reset outputs quiet",
              {st_rd_req, tx_valid, rx_ready, st_wr_go, st_wr_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_ready && phase == 0 && !tx_valid && !rx_ready, "R9 state after release",
              {cmd_ready, phase, tx_valid, rx_ready}, 6'b100000);
        run_cmd(1'b0, 32'd10, 0);
        run_cmd(1'b1, 32'd20, 0);
        run_cmd(1'b0, 32'h100, 1);
        run_cmd(1'b0, 32'hFFFF_FFFE, 3);
        run_cmd(1'b1, 32'h40, 1);
        run_cmd(1'b1, 32'hFFFF_FFFF, 2);
        for (int k = 0; k < 6; k++) begin
            run_cmd(1'($urandom % 2), $urandom, int'($urandom % 4));
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule